// File: doc/BRIEF.md
# Double-Buffered Timer Update Controller

This block holds the period and compare/capture settings of a timer/counter. Each setting has a buffer register and a buffer-valid flag. Software writes only the buffers. A buffer reaches its active register on an update, which is either the counter wrapping or a command from software. A lock bit holds transfers back, so software can load several buffers and have them take effect together on one update. A channel can be switched to capture mode. In that mode a capture event copies the counter into the channel's buffer and raises its flag, and software clears that flag on its own.

The control word is reached through a pair of write strobes. One strobe clears the bits written as 1 and the other sets them. Both read back through one port. The control word holds the direction bit, the lock bit and a two-bit command field. The commands are forced update, restart and hard reset. A hard reset acts only while the counter is stopped. A small up/down counter produces the wrap update. It does not generate waveforms, drive pins or raise interrupts.

Top module: `tbc_top`

## Requirements
- R1: After rst_n is low at a clock edge, the counter is 0, the active period is all ones, the active compare values and all buffers are 0, and the flag and control words read 0.
- R2: A period buffer write sets flag bit 0 from the next cycle on. A write to channel k sets flag bit k+1. Neither write changes an active register.
- R3: On an update with the lock bit at 0, each non-capture buffer whose flag is set is copied to its active register, and those flags clear. An active register whose flag was clear keeps its value.
- R4: On an update with the lock bit at 1, no buffer is copied, and the flags stay set until an update happens with the lock at 0.
- R5: While run_i is 1 with direction 0, the counter rises by one each cycle. In the cycle where it equals the active period, update_o is 1 and the counter wraps to 0, so the update repeats every period+1 cycles.
- R6: While run_i is 1 with direction 1, the counter falls by one each cycle. In the cycle where it is 0, update_o is 1 and the counter reloads the active period.
- R7: The command field is control bits 3:2. Code 01 forces update_o in the cycle after the write. Code 10 clears the counter to 0 and the direction bit to 0. Every command reads back as 00 once it has acted.
- R8: Command 11 while run_i is 0 returns all state to the R1 values. While run_i is 1 it is ignored: the buffers, active registers, flags, lock and direction are unchanged, and the field still clears.
- R9: Control bit 0 is direction (1 = down) and bit 1 is lock. Bits 7:4 read 0. The set strobe ORs the written 1s in, the clear strobe removes them, and the read port shows the current value.
- R10: The flag word has bit 0 for the period and bits 4:1 for channels 3 to 0, and bits 7:5 read 0. Its own set and clear strobes change the flags in the same way as the R9 strobes change the control word.
- R11: For a channel with cap_mode_i set, a capture event loads the counter into its buffer and sets its flag, and software buffer writes are ignored. An update, locked or not, neither copies that buffer nor clears that flag. cap_flag_clr_i clears the flag.
- R12: While run_i is 0 and no command is pending, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Counter clock enable; 0 is the off state |
| ctrl_clr_we_i | input | 1 | Clear strobe for the control word |
| ctrl_set_we_i | input | 1 | Set strobe for the control word |
| ctrl_wdata_i | input | 8 | Bit mask for the control strobes |
| ctrl_rdata_o | output | 8 | Current control word |
| flag_clr_we_i | input | 1 | Clear strobe for the flag word |
| flag_set_we_i | input | 1 | Set strobe for the flag word |
| flag_wdata_i | input | 8 | Bit mask for the flag strobes |
| flag_rdata_o | output | 8 | Current buffer-valid flags |
| per_buf_we_i | input | 1 | Period buffer write |
| per_buf_wdata_i | input | CNT_W | Period buffer data |
| cc_buf_we_i | input | NUM_CH | Per-channel buffer write |
| cc_buf_wdata_i | input | CNT_W | Channel buffer data |
| cap_mode_i | input | NUM_CH | Per-channel capture mode |
| cap_evt_i | input | NUM_CH | Per-channel capture event |
| cap_flag_clr_i | input | NUM_CH | Per-channel capture flag clear |
| cnt_o | output | CNT_W | Counter value |
| per_act_o | output | CNT_W | Active period |
| cc_act_o | output | NUM_CH*CNT_W | Active compare values, channel 0 in the low bits |
| cc_buf_o | output | NUM_CH*CNT_W | Buffer contents, channel 0 in the low bits |
| update_o | output | 1 | Update condition in this cycle |

## Verification
The counter is swept over periods 1 to 6 in both directions. Its value and the update strobe are checked each cycle against a value counted in the bench. This separates an off-by-one wrap point from a wrong reload value. Buffer transfers are tried with all flags set, with a single flag set and with the lock held. These show whether the copy follows each channel's own flag and whether the lock defers the copy without dropping it. The hard reset command is issued once while the counter runs and once while it is stopped, so an ignored command and an applied one can be told apart.

// File: rtl/tbc_pkg.sv
// Package: shared command codes and control-word bit positions.
// Assumes an 8-bit control word and an 8-bit flag word.
package tbc_pkg;
    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_UPDATE  = 2'b01,
        CMD_RESTART = 2'b10,
        CMD_HARDRST = 2'b11
    } tbc_cmd_e;

    localparam int CTRL_DIR_BIT  = 0;
    localparam int CTRL_LOCK_BIT = 1;
    localparam int CTRL_CMD_LO   = 2;
    localparam int REG_W         = 8;
endpackage

// File: rtl/tbc_ctrl_reg.sv
// Control word written through clear/set strobes.
// Holds direction, lock and command. A command clears itself in the cycle it
// acts. A restart drops the direction to up, and a hard reset zeroes the word.
// Assumes the strobes are single-cycle.
module tbc_ctrl_reg
    import tbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic             set_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             restart,
    input  logic             hrst,
    output logic [REG_W-1:0] ctrl_q,
    output logic             dir,
    output logic             lock,
    output tbc_cmd_e         cmd
);
    localparam logic [REG_W-1:0] USED_MASK = REG_W'(8'h0F);
    localparam logic [REG_W-1:0] CMD_MASK  = REG_W'(8'h0C);

    logic [REG_W-1:0] nxt;

    // Next value: self-clear the command, apply restart, then the strobes.
    always_comb begin
        nxt = ctrl_q & ~CMD_MASK;
        if (restart) nxt[CTRL_DIR_BIT] = 1'b0;
        if (clr_we)  nxt = nxt & ~wdata;
        if (set_we)  nxt = nxt | wdata;
        nxt = nxt & USED_MASK;
    end

    // Register the control word; a hard reset overrides the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || hrst) ctrl_q <= '0;
        else                ctrl_q <= nxt;
    end

    assign dir  = ctrl_q[CTRL_DIR_BIT];
    assign lock = ctrl_q[CTRL_LOCK_BIT];
    assign cmd  = tbc_cmd_e'(ctrl_q[CTRL_CMD_LO +: 2]);
endmodule

// File: rtl/tbc_counter.sv
// Up/down counter that flags the terminal count.
// Counting up, it wraps from the period to zero. Counting down, it reloads the
// period after reaching zero. It holds while run is low. Restart and hard
// reset clear it.
module tbc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dir,
    input  logic [CNT_W-1:0] per,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // Terminal count reached in this cycle while running.
    always_comb wrap = run && (dir ? (cnt == '0) : (cnt == per));

    // Advance, wrap or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (wrap)      cnt <= dir ? per : '0;
        else if (run)       cnt <= dir ? cnt - 1'b1 : cnt + 1'b1;
    end
endmodule

// File: rtl/tbc_slot.sv
// One buffered setting: buffer, active register and buffer-valid flag.
// In compare mode, the buffer takes software writes and moves to the active
// register on an unlocked update. With HAS_CAP set and capture mode selected,
// the buffer takes the counter on a capture event and updates leave it alone.
module tbc_slot #(
    parameter int               CNT_W   = 16,
    parameter bit               HAS_CAP = 1'b1,
    parameter logic [CNT_W-1:0] ACT_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hrst,
    input  logic             buf_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             cap_mode,
    input  logic             cap_evt,
    input  logic             cap_clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             xfer,
    input  logic             flag_set,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] buf_q,
    output logic [CNT_W-1:0] act_q,
    output logic             valid_q
);
    logic capm;
    logic valid_nxt;

    // Capture behaviour exists only in variants built with it.
    always_comb capm = HAS_CAP && cap_mode;

    // Flag: set by a write, capture or software set; cleared by its owner's event.
    always_comb begin
        valid_nxt = valid_q;
        if (capm) begin
            if (cap_clr) valid_nxt = 1'b0;
        end else if (xfer) begin
            valid_nxt = 1'b0;
        end
        if (flag_clr) valid_nxt = 1'b0;
        if ((capm && cap_evt) || (!capm && buf_we) || flag_set) valid_nxt = 1'b1;
    end

    // Buffer, active value and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || hrst) begin
            buf_q   <= '0;
            act_q   <= ACT_RST;
            valid_q <= 1'b0;
        end else begin
            if (capm && cap_evt)       buf_q <= cnt;
            else if (!capm && buf_we)  buf_q <= wdata;
            if (!capm && xfer && valid_q) act_q <= buf_q;
            valid_q <= valid_nxt;
        end
    end
endmodule

// File: rtl/tbc_top.sv
// Timer update controller: the period slot and NUM_CH channel slots, the
// control word, the flag word and the counter that makes the wrap update.
// Assumes NUM_CH <= 7 so the flags fit in the 8-bit flag word.
module tbc_top
    import tbc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    ctrl_clr_we_i,
    input  logic                    ctrl_set_we_i,
    input  logic [7:0]              ctrl_wdata_i,
    output logic [7:0]              ctrl_rdata_o,
    input  logic                    flag_clr_we_i,
    input  logic                    flag_set_we_i,
    input  logic [7:0]              flag_wdata_i,
    output logic [7:0]              flag_rdata_o,
    input  logic                    per_buf_we_i,
    input  logic [CNT_W-1:0]        per_buf_wdata_i,
    input  logic [NUM_CH-1:0]       cc_buf_we_i,
    input  logic [CNT_W-1:0]        cc_buf_wdata_i,
    input  logic [NUM_CH-1:0]       cap_mode_i,
    input  logic [NUM_CH-1:0]       cap_evt_i,
    input  logic [NUM_CH-1:0]       cap_flag_clr_i,
    output logic [CNT_W-1:0]        cnt_o,
    output logic [CNT_W-1:0]        per_act_o,
    output logic [NUM_CH*CNT_W-1:0] cc_act_o,
    output logic [NUM_CH*CNT_W-1:0] cc_buf_o,
    output logic                    update_o
);
    localparam int FLAG_W = NUM_CH + 1;

    logic        dir, lock, wrap, hrst, restart, fupd, xfer;
    tbc_cmd_e    cmd;
    logic [FLAG_W-1:0] valid;
    logic [FLAG_W-1:0] fset, fclr;
    logic [CNT_W-1:0]  per_buf_unused;

    // Decode the pending command; a hard reset needs the counter off.
    always_comb begin
        fupd    = (cmd == CMD_UPDATE);
        restart = (cmd == CMD_RESTART);
        hrst    = (cmd == CMD_HARDRST) && !run_i;
        xfer    = update_o && !lock;
        fset    = flag_set_we_i ? flag_wdata_i[FLAG_W-1:0] : '0;
        fclr    = flag_clr_we_i ? flag_wdata_i[FLAG_W-1:0] : '0;
    end

    tbc_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_we(ctrl_clr_we_i), .set_we(ctrl_set_we_i),
        .wdata(ctrl_wdata_i), .restart(restart), .hrst(hrst), .ctrl_q(ctrl_rdata_o),
        .dir(dir), .lock(lock), .cmd(cmd)
    );

    tbc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_i), .dir(dir), .per(per_act_o),
        .clr(restart || hrst), .cnt(cnt_o), .wrap(wrap)
    );

    // Update condition: terminal count or forced command.
    always_comb update_o = wrap || fupd;

    tbc_slot #(.CNT_W(CNT_W), .HAS_CAP(1'b0), .ACT_RST({CNT_W{1'b1}})) u_per (
        .clk(clk), .rst_n(rst_n), .hrst(hrst), .buf_we(per_buf_we_i),
        .wdata(per_buf_wdata_i), .cap_mode(1'b0), .cap_evt(1'b0), .cap_clr(1'b0),
        .cnt(cnt_o), .xfer(xfer), .flag_set(fset[0]), .flag_clr(fclr[0]),
        .buf_q(per_buf_unused), .act_q(per_act_o), .valid_q(valid[0])
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        tbc_slot #(.CNT_W(CNT_W), .HAS_CAP(1'b1), .ACT_RST('0)) u_ch (
            .clk(clk), .rst_n(rst_n), .hrst(hrst), .buf_we(cc_buf_we_i[k]),
            .wdata(cc_buf_wdata_i), .cap_mode(cap_mode_i[k]), .cap_evt(cap_evt_i[k]),
            .cap_clr(cap_flag_clr_i[k]), .cnt(cnt_o), .xfer(xfer),
            .flag_set(fset[k+1]), .flag_clr(fclr[k+1]),
            .buf_q(cc_buf_o[k*CNT_W +: CNT_W]), .act_q(cc_act_o[k*CNT_W +: CNT_W]),
            .valid_q(valid[k+1])
        );
    end

    // Flag word: period in bit 0, channels above, reserved bits zero.
    always_comb flag_rdata_o = 8'(valid);
endmodule

// File: rtl/tbc_chk.sv
// Checker for tbc_top: relates the ports over time. Attached by bind below.
module tbc_chk #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             ctrl_set_we_i,
    input logic             ctrl_clr_we_i,
    input logic [7:0]       ctrl_rdata_o,
    input logic             flag_set_we_i,
    input logic [7:0]       flag_rdata_o,
    input logic             per_buf_we_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic [CNT_W-1:0] per_act_o,
    input logic             update_o
);
    logic hr_now;
    always_comb hr_now = (ctrl_rdata_o[3:2] == 2'b11) && !run_i;

    // R2
    per_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_buf_we_i && !hr_now |=> flag_rdata_o[0]);

    // R3
    upd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_o && !ctrl_rdata_o[1] && !per_buf_we_i && !flag_set_we_i |=> !flag_rdata_o[0]);

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_o && ctrl_rdata_o[1] |=> $stable(per_act_o));

    // R7
    cmd_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata_o[3:2] != 2'b00) && !ctrl_set_we_i |=> ctrl_rdata_o[3:2] == 2'b00);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata_o[3:2] == 2'b10) && !ctrl_set_we_i |=> (cnt_o == '0) && !ctrl_rdata_o[0]);

    // R8
    hard_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hr_now |=> (flag_rdata_o == 8'h00) && (ctrl_rdata_o == 8'h00) && (cnt_o == '0));

    // R9
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata_o[7:4] == 4'h0);

    // R10
    flag_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata_o >> (NUM_CH + 1)) == 8'h00);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && (ctrl_rdata_o[3:2] == 2'b00) |=> $stable(cnt_o));
endmodule

bind tbc_top tbc_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ctrl_set_we_i(ctrl_set_we_i),
    .ctrl_clr_we_i(ctrl_clr_we_i), .ctrl_rdata_o(ctrl_rdata_o),
    .flag_set_we_i(flag_set_we_i), .flag_rdata_o(flag_rdata_o),
    .per_buf_we_i(per_buf_we_i), .cnt_o(cnt_o), .per_act_o(per_act_o),
    .update_o(update_o)
);

// File: tb/tbc_top_tb_top.sv
module tbc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b0;
    logic ctrl_clr_we_i = 1'b0, ctrl_set_we_i = 1'b0;
    logic [7:0] ctrl_wdata_i = '0, ctrl_rdata_o;
    logic flag_clr_we_i = 1'b0, flag_set_we_i = 1'b0;
    logic [7:0] flag_wdata_i = '0, flag_rdata_o;
    logic per_buf_we_i = 1'b0;
    logic [W-1:0] per_buf_wdata_i = '0;
    logic [N-1:0] cc_buf_we_i = '0;
    logic [W-1:0] cc_buf_wdata_i = '0;
    logic [N-1:0] cap_mode_i = '0, cap_evt_i = '0, cap_flag_clr_i = '0;
    logic [W-1:0] cnt_o, per_act_o;
    logic [N*W-1:0] cc_act_o, cc_buf_o;
    logic update_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbc_top #(.CNT_W(W), .NUM_CH(N)) dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ctrl_set(input logic [7:0] v);
        ctrl_set_we_i = 1'b1; ctrl_wdata_i = v; tick();
        ctrl_set_we_i = 1'b0;
    endtask

    task automatic ctrl_clr(input logic [7:0] v);
        ctrl_clr_we_i = 1'b1; ctrl_wdata_i = v; tick();
        ctrl_clr_we_i = 1'b0;
    endtask

    task automatic flag_set(input logic [7:0] v);
        flag_set_we_i = 1'b1; flag_wdata_i = v; tick();
        flag_set_we_i = 1'b0;
    endtask

    task automatic flag_clr(input logic [7:0] v);
        flag_clr_we_i = 1'b1; flag_wdata_i = v; tick();
        flag_clr_we_i = 1'b0;
    endtask

    task automatic wr_per(input logic [W-1:0] v);
        per_buf_we_i = 1'b1; per_buf_wdata_i = v; tick();
        per_buf_we_i = 1'b0;
    endtask

    task automatic wr_cc(input int k, input logic [W-1:0] v);
        cc_buf_we_i[k] = 1'b1; cc_buf_wdata_i = v; tick();
        cc_buf_we_i = '0;
    endtask

    // Command code placed into bits 3:2; returns after it has acted.
    task automatic command(input logic [1:0] c);
        ctrl_set({4'h0, c, 2'b00});
        tick();
    endtask

    function automatic int act_of(input int k);
        return int'(cc_act_o[k*W +: W]);
    endfunction

    function automatic int buf_of(input int k);
        return int'(cc_buf_o[k*W +: W]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        int expc;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 per_act", int'(per_act_o), 255);
        check("R1 cc_act", int'(cc_act_o), 0);
        check("R1 flags", int'(flag_rdata_o), 0);
        check("R1 ctrl", int'(ctrl_rdata_o), 0);

        // R2 buffer writes raise flags, actives untouched
        wr_per(8'd5);
        check("R2 per flag", int'(flag_rdata_o), 1);
        check("R2 per_act held", int'(per_act_o), 255);
        for (int k = 0; k < N; k++) begin
            wr_cc(k, W'(10 + k));
            check("R2 cc flag", int'(flag_rdata_o[k+1]), 1);
            check("R2 cc_act held", act_of(k), 0);
        end
        check("R2 all flags", int'(flag_rdata_o), 8'h1F);

        // R7 forced update strobes update_o; R3 transfer of all flagged buffers
        ctrl_set(8'h04);
        check("R7 forced update_o", int'(update_o), 1);
        tick();
        check("R3 per_act", int'(per_act_o), 5);
        for (int k = 0; k < N; k++) check("R3 cc_act", act_of(k), 10 + k);
        check("R3 flags cleared", int'(flag_rdata_o), 0);
        check("R7 cmd cleared", int'(ctrl_rdata_o), 0);

        // R3 only the flagged channel moves
        wr_cc(2, 8'h55);
        command(2'b01);
        check("R3 ch2 moved", act_of(2), 8'h55);
        check("R3 ch1 kept", act_of(1), 11);
        check("R3 per kept", int'(per_act_o), 5);

        // R4 lock defers transfer and keeps the flag
        ctrl_set(8'h02);
        wr_per(8'd9);
        command(2'b01);
        check("R4 per_act locked", int'(per_act_o), 5);
        check("R4 flag kept", int'(flag_rdata_o), 1);
        ctrl_clr(8'h02);
        command(2'b01);
        check("R4 per_act after unlock", int'(per_act_o), 9);
        check("R4 flag cleared", int'(flag_rdata_o), 0);

        // R9 clear/set access and reserved bits
        ctrl_set(8'hF3);
        check("R9 set", int'(ctrl_rdata_o), 8'h03);
        ctrl_clr(8'h01);
        check("R9 clear dir", int'(ctrl_rdata_o), 8'h02);
        ctrl_clr(8'h02);
        check("R9 clear lock", int'(ctrl_rdata_o), 0);

        // R10 flag word clear/set
        flag_set(8'hFF);
        check("R10 set masked", int'(flag_rdata_o), 8'h1F);
        flag_clr(8'h05);
        check("R10 clear", int'(flag_rdata_o), 8'h1A);
        flag_clr(8'hFF);
        check("R10 clear all", int'(flag_rdata_o), 0);

        // R5 up-count sweep
        for (int p = 1; p <= 6; p++) begin
            wr_per(W'(p));
            command(2'b01);
            command(2'b10);
            expc = 0;
            run_i = 1'b1;
            for (int n = 0; n < 2 * (p + 1) + 1; n++) begin
                #1;
                check("R5 update_o", int'(update_o), int'(expc == p));
                tick();
                expc = (expc == p) ? 0 : expc + 1;
                check("R5 cnt", int'(cnt_o), expc);
            end
            run_i = 1'b0;
        end

        // R6 down-count sweep
        for (int p = 1; p <= 6; p++) begin
            wr_per(W'(p));
            command(2'b01);
            command(2'b10);
            ctrl_set(8'h01);
            expc = 0;
            run_i = 1'b1;
            for (int n = 0; n < 2 * (p + 1) + 1; n++) begin
                #1;
                check("R6 update_o", int'(update_o), int'(expc == 0));
                tick();
                expc = (expc == 0) ? p : expc - 1;
                check("R6 cnt", int'(cnt_o), expc);
            end
            run_i = 1'b0;
            ctrl_clr(8'h01);
        end

        // R12 hold while stopped
        expc = int'(cnt_o);
        repeat (3) tick();
        check("R12 hold", int'(cnt_o), expc);

        // R11 capture mode on channel 1
        wr_per(8'd200);
        command(2'b01);
        command(2'b10);
        run_i = 1'b1;
        repeat (3) tick();
        run_i = 1'b0;
        check("R11 cnt setup", int'(cnt_o), 3);
        cap_mode_i[1] = 1'b1;
        wr_cc(1, 8'h77);
        check("R11 write ignored", buf_of(1), 11);
        check("R11 no flag on write", int'(flag_rdata_o[2]), 0);
        cap_evt_i[1] = 1'b1; tick(); cap_evt_i = '0;
        check("R11 captured", buf_of(1), 3);
        check("R11 flag set", int'(flag_rdata_o[2]), 1);
        command(2'b01);
        check("R11 no copy", act_of(1), 11);
        check("R11 flag survives update", int'(flag_rdata_o[2]), 1);
        cap_flag_clr_i[1] = 1'b1; tick(); cap_flag_clr_i = '0;
        check("R11 flag cleared", int'(flag_rdata_o[2]), 0);
        cap_mode_i = '0;

        // R8 hard reset ignored while running
        wr_cc(0, 8'h33);
        ctrl_set(8'h02);
        run_i = 1'b1;
        command(2'b11);
        run_i = 1'b0;
        check("R8 ignored ctrl", int'(ctrl_rdata_o), 8'h02);
        check("R8 ignored flag", int'(flag_rdata_o), 8'h02);
        check("R8 ignored per_act", int'(per_act_o), 200);
        check("R8 ignored cc_act", act_of(0), 10);

        // R8 hard reset applied while stopped
        command(2'b11);
        check("R8 cnt", int'(cnt_o), 0);
        check("R8 per_act", int'(per_act_o), 255);
        check("R8 cc_act", int'(cc_act_o), 0);
        check("R8 cc_buf", int'(cc_buf_o), 0);
        check("R8 flags", int'(flag_rdata_o), 0);
        check("R8 ctrl", int'(ctrl_rdata_o), 0);

        wrap_up();
    end
endmodule